// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block gathers eight interrupt request lines and presents a single interrupt output to a processor. It has a request register, a mask register and an in-service register. A small command/data register port programs it. A start command opens a short sequence of setup words. After that sequence, data writes load the mask and command writes issue end-of-interrupt and priority commands. The processor takes an interrupt by pulsing an acknowledge input. In that same cycle the block presents an 8-bit vector, and on the following clock edge it moves the winning request into service.

Priority is not tied to the input number. It is measured from a programmable rotation base, so input `i` ranks `(i - base) mod 8`, and 0 is the highest rank. Rotating end-of-interrupt commands and a set-priority command move the base. The trigger-control register selects edge or level behaviour for each input. Only the bits that its fixed write mask allows can be written. The master variant can ignore the in-service state of its cascade input when it compares priorities, which lets a downstream controller be granted again while the cascade input is already in service.

Top module: `rotpri_intc`

## Requirements
- R1: After reset, `int_out` is low and an acknowledge returns vector 0x07, since the vector base is 0 and no request is pending.
- R2: A command write with bit 4 set starts setup. It clears the request, mask, in-service, rotation base, vector base, trigger and mode state, and `int_out` is low in the next cycle. Bit 1 set means single mode, so the cascade word is skipped. Bit 0 set means a mode word follows. The data words then come in this order: base word, cascade word (when not in single mode), mode word (when requested).
- R3: The base word keeps only bits 7..3. A granted acknowledge returns that base plus the 3-bit input number.
- R4: A data write outside setup loads the mask register. A masked request never raises `int_out`.
- R5: `int_out` is high only when the best unmasked request ranks strictly higher than the best in-service input. A request at the same rank as the in-service input does not qualify.
- R6: An acknowledge while `int_out` is high sets the winner's in-service bit and clears its edge request. An acknowledge while `int_out` is low returns base+7 and changes no state.
- R7: Mode word bit 1 selects auto end-of-interrupt. In that mode an acknowledge leaves the in-service register unchanged.
- R8: Command 0x20 (bits 7..5 = 001, bits 4..3 = 00) clears the in-service bit that has the highest rank.
- R9: Command 0x60|n clears in-service bit n.
- R10: Command 0xA0 clears the highest-ranked in-service bit k and sets the rotation base to (k+1) mod 8. Command 0xE0|n clears bit n and sets the base to (n+1) mod 8.
- R11: Command 0xC0|n sets the rotation base to (n+1) mod 8 and changes no in-service bit.
- R12: In edge mode a request is set only on a 0-to-1 input transition and is held until it is acknowledged. In level mode (trigger bit = 1) the request follows the line, including after an acknowledge. Trigger writes are ANDed with 0xF8 on the master and with 0xDE on the slave.
- R13: On the master, mode word bit 4 selects special fully nested mode. In that mode in-service bit 2 (the cascade input) is left out of the comparison that drives `int_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr_sel | input | 1 | 0 selects the command port, 1 selects the data port |
| wr_data | input | 8 | Write data |
| trig_wr | input | 1 | Trigger-control register write strobe |
| trig_wdata | input | 8 | Trigger bits, 1 = level mode |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | Acknowledge strobe |
| ack_vec | output | 8 | Vector returned during the acknowledge cycle |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest situations to set up are those where the rotation base decides the outcome. One is a pending request that would outrank the in-service input under one base and lose to it under another. The other is the master's cascade input being granted a second time while it is already in service. To reach the first, the stimulus chains set-priority, rotating-specific and rotating non-specific commands with acknowledges. It then raises a probe line whose rank is low under the new base but would be high under the previous one. To reach the second, the stimulus runs the four-word setup with special nesting enabled, acknowledges input 2, pulses that line again, and watches `int_out`. The same sequence also confirms that the cascade word was consumed, because a misplaced word would otherwise land in the mask.

// File: rtl/rotpri_intc.sv
module rotpri_intc #(
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr_sel,
  input  logic [7:0] wr_data,
  input  logic       trig_wr,
  input  logic [7:0] trig_wdata,
  input  logic [7:0] irq_in,
  input  logic       ack,
  output logic [7:0] ack_vec,
  output logic       int_out
);

  localparam logic [7:0] TRIG_MASK = IS_MASTER ? 8'hF8 : 8'hDE;
  localparam logic [7:0] CASC_BIT  = 8'h01 << CASCADE_LINE;

  typedef enum logic [1:0] {S_IDLE, S_BASE, S_CASC, S_MODE} init_t;

  function automatic logic [3:0] rank(input logic [7:0] m, input logic [2:0] r);
    logic [3:0] p;
    p = 4'd8;
    for (int k = 7; k >= 0; k--)
      if (m[3'(int'(r) + k)]) p = 4'(k);
    return p;
  endfunction

  init_t      st;
  logic [7:0] irr, imr, isr, elcr, last_lvl;
  logic [2:0] rot;
  logic [4:0] base_hi;
  logic       single, init4, aeoi, sfnm;

  logic       cmd_wr, dat_wr, is_init, is_ocw2, take;
  logic [7:0] pend, isr_cmp, eoi_clr, ack_set, clr_edge, irr_nxt;
  logic [3:0] p_req, p_cmp, p_svc;
  logic [2:0] win, top_svc, lvl, rot_nxt;

  assign cmd_wr  = wr_en & ~addr_sel;
  assign dat_wr  = wr_en & addr_sel;
  assign is_init = cmd_wr & wr_data[4];
  assign is_ocw2 = cmd_wr & ~wr_data[4] & ~wr_data[3];
  assign lvl     = wr_data[2:0];

  assign pend    = irr & ~imr;
  assign isr_cmp = (sfnm && IS_MASTER) ? (isr & ~CASC_BIT) : isr;
  assign p_req   = rank(pend, rot);
  assign p_cmp   = rank(isr_cmp, rot);
  assign p_svc   = rank(isr, rot);
  assign int_out = p_req < p_cmp;
  assign win     = p_req[2:0] + rot;
  assign top_svc = p_svc[2:0] + rot;

  assign take     = ack & int_out;
  assign ack_vec  = {base_hi, take ? win : 3'd7};
  assign clr_edge = take ? (8'h01 << win) : 8'h00;
  assign ack_set  = (take && !aeoi) ? (8'h01 << win) : 8'h00;
  assign irr_nxt  = (elcr & irq_in) | (~elcr & ((irr & ~clr_edge) | (irq_in & ~last_lvl)));

  always_comb begin
    eoi_clr = 8'h00;
    rot_nxt = rot;
    if (is_ocw2) begin
      case (wr_data[7:5])
        3'b001: if (!p_svc[3]) eoi_clr = 8'h01 << top_svc;
        3'b101: if (!p_svc[3]) begin
          eoi_clr = 8'h01 << top_svc;
          rot_nxt = top_svc + 3'd1;
        end
        3'b011: eoi_clr = 8'h01 << lvl;
        3'b111: begin
          eoi_clr = 8'h01 << lvl;
          rot_nxt = lvl + 3'd1;
        end
        3'b110: rot_nxt = lvl + 3'd1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      irr <= '0; imr <= '0; isr <= '0; elcr <= '0; last_lvl <= '0;
      rot <= '0; base_hi <= '0;
      single <= 1'b0; init4 <= 1'b0; aeoi <= 1'b0; sfnm <= 1'b0;
    end else if (is_init) begin
      st <= S_BASE;
      irr <= '0; imr <= '0; isr <= '0; elcr <= '0; last_lvl <= '0;
      rot <= '0; base_hi <= '0;
      aeoi <= 1'b0; sfnm <= 1'b0;
      single <= wr_data[1];
      init4  <= wr_data[0];
    end else begin
      last_lvl <= irq_in;
      irr <= irr_nxt;
      isr <= (isr & ~eoi_clr) | ack_set;
      rot <= rot_nxt;
      if (trig_wr) elcr <= trig_wdata & TRIG_MASK;
      if (dat_wr) begin
        case (st)
          S_IDLE: imr <= wr_data;
          S_BASE: begin
            base_hi <= wr_data[7:3];
            st <= single ? (init4 ? S_MODE : S_IDLE) : S_CASC;
          end
          S_CASC: st <= init4 ? S_MODE : S_IDLE;
          S_MODE: begin
            aeoi <= wr_data[1];
            sfnm <= wr_data[4];
            st   <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_init |=> !int_out);

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && st == S_IDLE) |=> imr == $past(wr_data));

  // R5
  out_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != 8'h00);

  // R6
  ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi && !is_init) |=> isr != 8'h00);

  // R11
  set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[7:3] == 5'b11000) |=> rot == 3'($past(wr_data[2:0]) + 3'd1));

endmodule

// File: tb/rotpri_intc_tb.sv
`timescale 1ns/1ps
module rotpri_intc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, addr_sel = 1'b0, trig_wr = 1'b0, ack = 1'b0;
  logic [7:0] wr_data = '0, trig_wdata = '0, irq_in = '0;
  logic [7:0] ack_vec;
  logic int_out;
  int total = 0, bad = 0;
  bit finished = 0;

  rotpri_intc dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_sel(addr_sel), .wr_data(wr_data),
    .trig_wr(trig_wr), .trig_wdata(trig_wdata), .irq_in(irq_in), .ack(ack),
    .ack_vec(ack_vec), .int_out(int_out));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input logic exp);
    chk(req, {7'd0, int_out}, {7'd0, exp});
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr_sel = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d); wr(1'b0, d); endtask
  task automatic dat(input logic [7:0] d); wr(1'b1, d); endtask

  task automatic trig(input logic [7:0] d);
    @(negedge clk); trig_wr = 1'b1; trig_wdata = d;
    @(negedge clk); trig_wr = 1'b0;
  endtask

  task automatic line(input int i, input logic v);
    @(negedge clk); irq_in[i] = v;
    @(negedge clk);
  endtask

  task automatic take_ack(input string req, input logic [7:0] exp);
    @(negedge clk); ack = 1'b1; #1 chk(req, ack_vec, exp);
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset;
    chk_int("R1 int low after reset", 1'b0);
    take_ack("R1 spurious vector after reset", 8'h07);
    chk_int("R1 still quiet", 1'b0);
  endtask

  task automatic t_single_init;
    cmd(8'h12); dat(8'h47);
    dat(8'hFF);
    line(3, 1'b1);
    chk_int("R4 masked request hidden", 1'b0);
    dat(8'h00);
    chk_int("R2 R4 unmask shows request", 1'b1);
    take_ack("R3 vector base plus input", 8'h43);
    chk_int("R6 serviced request drops output", 1'b0);
    line(3, 1'b0); line(3, 1'b1);
    chk_int("R5 equal rank does not interrupt", 1'b0);
    cmd(8'h63);
    chk_int("R9 specific EOI frees level", 1'b1);
    take_ack("R3 second grant", 8'h43);
    cmd(8'h63); line(3, 1'b0);
    chk_int("R9 all clear", 1'b0);
  endtask

  task automatic t_nesting;
    line(3, 1'b1);
    take_ack("R6 grant input3", 8'h43);
    line(3, 1'b0);
    line(5, 1'b1);
    chk_int("R5 lower rank blocked", 1'b0);
    take_ack("R6 spurious while blocked", 8'h47);
    line(1, 1'b1);
    chk_int("R5 higher rank interrupts", 1'b1);
    take_ack("R6 grant input1", 8'h41);
    cmd(8'h20);
    chk_int("R8 NS EOI cleared input1 only", 1'b0);
    cmd(8'h20);
    chk_int("R8 NS EOI cleared input3, pending 5 kept", 1'b1);
    dat(8'h20);
    chk_int("R4 mask bit5", 1'b0);
    dat(8'h00);
    chk_int("R4 unmask bit5", 1'b1);
    take_ack("R6 grant input5", 8'h45);
    cmd(8'h65);
    chk_int("R9 clear input5", 1'b0);
    line(1, 1'b0); line(5, 1'b0);
  endtask

  task automatic t_rotation;
    cmd(8'hC4);
    line(4, 1'b1); line(6, 1'b1);
    take_ack("R11 base 5 ranks input6 over input4", 8'h46);
    chk_int("R11 input4 below input6", 1'b0);
    cmd(8'hE6);
    chk_int("R10 rotate specific clears 6", 1'b1);
    take_ack("R10 grant input4", 8'h44);
    line(4, 1'b0); line(6, 1'b0);
    line(2, 1'b1);
    chk_int("R10 base 7 ranks 2 over 4", 1'b1);
    take_ack("R10 grant input2", 8'h42);
    cmd(8'hA0);
    line(1, 1'b1);
    chk_int("R10 rotate NS moved base to 3", 1'b0);
    cmd(8'h64);
    chk_int("R9 input1 now free", 1'b1);
    take_ack("R10 grant input1", 8'h41);
    cmd(8'h61);
    line(1, 1'b0); line(2, 1'b0);
    cmd(8'hC7);
    chk_int("R11 idle after restore", 1'b0);
  endtask

  task automatic t_trigger;
    trig(8'hFF);
    line(5, 1'b1);
    chk_int("R12 level request", 1'b1);
    take_ack("R12 grant level input5", 8'h45);
    chk_int("R12 in service", 1'b0);
    cmd(8'h65);
    chk_int("R12 level request survives ack", 1'b1);
    line(5, 1'b0);
    chk_int("R12 level request follows line", 1'b0);
    line(1, 1'b1);
    take_ack("R12 grant input1", 8'h41);
    cmd(8'h61);
    chk_int("R12 input1 stays edge, no re-request", 1'b0);
    line(1, 1'b0);
    trig(8'h00);
  endtask

  task automatic t_auto_eoi;
    line(6, 1'b1);
    chk_int("R2 pending before setup", 1'b1);
    cmd(8'h13);
    chk_int("R2 setup drops output", 1'b0);
    @(negedge clk);
    chk_int("R2 held line seen again after setup", 1'b1);
    dat(8'h80); dat(8'h02);
    take_ack("R7 vector after auto EOI setup", 8'h86);
    line(7, 1'b1);
    chk_int("R7 no in-service bit left", 1'b1);
    take_ack("R7 grant input7", 8'h87);
    line(6, 1'b0); line(7, 1'b0);
  endtask

  task automatic t_fully_nested;
    cmd(8'h11); dat(8'h00); dat(8'h04); dat(8'h10);
    line(2, 1'b1);
    take_ack("R13 grant cascade input", 8'h02);
    line(2, 1'b0); line(2, 1'b1);
    chk_int("R13 cascade input granted again", 1'b1);
    take_ack("R13 second cascade grant", 8'h02);
    line(4, 1'b1);
    chk_int("R2 R13 cascade word consumed, mask clear", 1'b1);
    take_ack("R13 lower input passes cascade service", 8'h04);
    line(2, 1'b0); line(4, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_init();
    t_nesting();
    t_rotation();
    t_trigger();
    t_auto_eoi();
    t_fully_nested();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule